// File: doc/BRIEF.md
# Link Power State Controller

This block decides how far the interface between a physical layer and its link-layer controller is powered down. It watches one link power status level, already synchronous to the local clock, and measures how long that level has stayed low. A short low time changes nothing. A low time longer than a first threshold puts the interface into a low-power reset state. A low time longer than a second, larger threshold puts it into a low-power disabled state. In the reset state the control and data outputs are held at zero and link requests are ignored, while the link clock keeps running. In the disabled state the link clock is stopped as well.

When the level is seen high again, the interface goes through a fixed re-initialization period and then returns to normal operation. If the disabled state had been reached, a one-cycle bus reset request is issued as the interface starts re-initializing, so that the node can announce that its link is reachable again. Hardware reset holds the interface in the disabled state. A software link-control bit plays no part here, so the block has no input for it. The thresholds and the length of re-initialization are parameters counted in clock cycles, with DISABLE_CYCLES greater than RESET_CYCLES.

Top module: `lps_iface_ctrl`

## Requirements
- R1: When the status input is sampled low on RESET_CYCLES or fewer consecutive rising edges and then sampled high, state_o stays at NORMAL (code 0) and ctl_data_en_o, lreq_en_o and lclk_en_o all stay 1.
- R2: When the status input is sampled low on more than RESET_CYCLES consecutive edges, state_o reads LP_RESET (code 1) from the edge that follows the (RESET_CYCLES+1)th low sample. This holds even if the input is high at that edge.
- R3: While state_o is LP_RESET, ctl_data_en_o and lreq_en_o are 0 and lclk_en_o is 1.
- R4: When the status input is sampled low on more than DISABLE_CYCLES consecutive edges, state_o reads LP_DISABLED (code 2) from the edge that follows the (DISABLE_CYCLES+1)th low sample. It remains there while the input stays low, and all three enables are 0 in that state.
- R5: A high sample in LP_DISABLED moves state_o to INIT (code 3) at the next edge. A high sample in LP_RESET does the same, unless the disable threshold was passed in that same cycle.
- R6: INIT lasts exactly INIT_CYCLES cycles. During INIT, ctl_data_en_o and lreq_en_o are 0 and lclk_en_o is 1. After INIT, state_o reads NORMAL.
- R7: On entry to INIT from LP_DISABLED, bus_reset_req_o is 1 for the first INIT cycle only.
- R8: On entry to INIT from LP_RESET, bus_reset_req_o stays 0.
- R9: While rst_n is low, state_o is LP_DISABLED at once, all enables are 0 and bus_reset_req_o is 0. After release the block behaves as in LP_DISABLED, so a high input leads to INIT with a bus reset request.
- R10: Any high sample clears the measured low time, so separate low runs of RESET_CYCLES or fewer samples never add up to a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| lps_i | input | 1 | Link power status level, synchronous to clk |
| state_o | output | 2 | Interface state: 0 NORMAL, 1 LP_RESET, 2 LP_DISABLED, 3 INIT |
| ctl_data_en_o | output | 1 | Enable for the control and data outputs to the link |
| lreq_en_o | output | 1 | Enable for accepting link requests |
| lclk_en_o | output | 1 | Enable for the link clock output |
| bus_reset_req_o | output | 1 | One-cycle request for a bus reset |

## Verification
Every state is decoded straight from a register, with no further pipeline stage. A wrong state or a wrong threshold comparison therefore shows on state_o and on the three enables in the same cycle as the wrong transition. The stimulus places low runs exactly at each threshold and one sample beyond it, so an off-by-one in the low-time counter changes the observed state at a known edge. A missing, doubled or misplaced bus reset request shows up in the first INIT cycle. A count of pulses over the whole run catches any spurious request.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    LS_NORMAL   = 2'd0,
    LS_RESET    = 2'd1,
    LS_DISABLED = 2'd2,
    LS_INIT     = 2'd3
  } lps_state_e;
endpackage

// File: rtl/lps_low_timer.sv
// Measures consecutive low samples of the status input and flags
// when the reset and disable thresholds have been exceeded.
module lps_low_timer #(
  parameter int unsigned RESET_CYCLES   = 8,
  parameter int unsigned DISABLE_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lps_i,
  output logic rst_over_o,
  output logic dis_over_o
);
  localparam int unsigned SAT = DISABLE_CYCLES + 1;
  localparam int unsigned CW  = $clog2(SAT + 1);
  localparam logic [CW-1:0] SAT_V = CW'(SAT);
  localparam logic [CW-1:0] RST_V = CW'(RESET_CYCLES);
  localparam logic [CW-1:0] DIS_V = CW'(DISABLE_CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = lps_i || (cnt_q != SAT_V);
    cnt_d  = lps_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign rst_over_o = cnt_q > RST_V;
  assign dis_over_o = cnt_q > DIS_V;
endmodule

// File: rtl/lps_state_fsm.sv
// Interface state sequencing, re-initialization timing and the bus
// reset request.
module lps_state_fsm
  import lps_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lps_i,
  input  logic       rst_over_i,
  input  logic       dis_over_i,
  output lps_state_e state_o,
  output logic       bus_rst_req_o
);
  localparam int unsigned IW = $clog2(INIT_CYCLES + 1);
  localparam logic [IW-1:0] LAST_V = IW'(INIT_CYCLES - 1);

  lps_state_e    state_q, state_d;
  logic [IW-1:0] init_q, init_d;
  logic          init_en;
  logic          init_done;
  logic          pulse_q, pulse_d;

  assign init_done = (init_q == LAST_V);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LS_NORMAL: begin
        if (rst_over_i) state_d = LS_RESET;
      end
      LS_RESET: begin
        if (dis_over_i)  state_d = LS_DISABLED;
        else if (lps_i)  state_d = LS_INIT;
      end
      LS_DISABLED: begin
        if (lps_i) state_d = LS_INIT;
      end
      LS_INIT: begin
        if (init_done) state_d = LS_NORMAL;
      end
      default: state_d = LS_DISABLED;
    endcase
  end

  always_comb begin
    init_en = (state_q == LS_INIT) || (init_q != '0);
    init_d  = (state_q == LS_INIT) ? init_q + 1'b1 : '0;
    pulse_d = (state_q == LS_DISABLED) && (state_d == LS_INIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_DISABLED;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
    end else if (init_en) begin
      init_q <= init_d;
    end
  end

  assign state_o       = state_q;
  assign bus_rst_req_o = pulse_q;
endmodule

// File: rtl/lps_out_gate.sv
// Decodes the interface state into the three gating enables.
module lps_out_gate
  import lps_pkg::*;
(
  input  lps_state_e state_i,
  output logic       ctl_data_en_o,
  output logic       lreq_en_o,
  output logic       lclk_en_o
);
  always_comb begin
    ctl_data_en_o = 1'b0;
    lreq_en_o     = 1'b0;
    lclk_en_o     = 1'b0;
    unique case (state_i)
      LS_NORMAL: begin
        ctl_data_en_o = 1'b1;
        lreq_en_o     = 1'b1;
        lclk_en_o     = 1'b1;
      end
      LS_RESET:    lclk_en_o = 1'b1;
      LS_INIT:     lclk_en_o = 1'b1;
      LS_DISABLED: lclk_en_o = 1'b0;
      default:     lclk_en_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lps_iface_ctrl.sv
module lps_iface_ctrl
  import lps_pkg::*;
#(
  parameter int unsigned RESET_CYCLES   = 8,
  parameter int unsigned DISABLE_CYCLES = 20,
  parameter int unsigned INIT_CYCLES    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lps_i,
  output logic [1:0] state_o,
  output logic       ctl_data_en_o,
  output logic       lreq_en_o,
  output logic       lclk_en_o,
  output logic       bus_reset_req_o
);
  logic       rst_over;
  logic       dis_over;
  lps_state_e st;

  lps_low_timer #(
    .RESET_CYCLES  (RESET_CYCLES),
    .DISABLE_CYCLES(DISABLE_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .lps_i     (lps_i),
    .rst_over_o(rst_over),
    .dis_over_o(dis_over)
  );

  lps_state_fsm #(
    .INIT_CYCLES(INIT_CYCLES)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .lps_i        (lps_i),
    .rst_over_i   (rst_over),
    .dis_over_i   (dis_over),
    .state_o      (st),
    .bus_rst_req_o(bus_reset_req_o)
  );

  lps_out_gate u_gate (
    .state_i      (st),
    .ctl_data_en_o(ctl_data_en_o),
    .lreq_en_o    (lreq_en_o),
    .lclk_en_o    (lclk_en_o)
  );

  assign state_o = st;
endmodule

// File: rtl/lps_iface_ctrl_chk.sv
module lps_iface_ctrl_chk #(
  parameter int unsigned INIT_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lps_i,
  input logic [1:0] state_o,
  input logic       ctl_data_en_o,
  input logic       lreq_en_o,
  input logic       lclk_en_o,
  input logic       bus_reset_req_o
);
  localparam logic [1:0] ST_NORM = 2'd0;
  localparam logic [1:0] ST_RST  = 2'd1;
  localparam logic [1:0] ST_DIS  = 2'd2;
  localparam logic [1:0] ST_INIT = 2'd3;

  logic [31:0] init_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_run <= '0;
    end else if (state_o == ST_INIT) begin
      init_run <= init_run + 1'b1;
    end else begin
      init_run <= '0;
    end
  end

  assert_reset_gating_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_RST) |-> (lclk_en_o && !ctl_data_en_o && !lreq_en_o));

  assert_disabled_gating_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_DIS) |-> (!lclk_en_o && !ctl_data_en_o && !lreq_en_o));

  assert_disabled_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_DIS && lps_i) |=> (state_o == ST_INIT));

  assert_init_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_INIT) |-> (init_run < INIT_CYCLES));

  assert_init_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_INIT && init_run == INIT_CYCLES - 1) |=> (state_o == ST_NORM));

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_req_o |=> !bus_reset_req_o);

  assert_pulse_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_req_o |-> (state_o == ST_INIT && $past(state_o) == ST_DIS));

  assert_no_pulse_from_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_INIT && $past(state_o) == ST_RST) |-> !bus_reset_req_o);

  assert_normal_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_NORM && lps_i && $past(lps_i)) |=> (state_o == ST_NORM));
endmodule

bind lps_iface_ctrl lps_iface_ctrl_chk #(.INIT_CYCLES(INIT_CYCLES)) u_chk (.*);

// File: tb/test_lps_iface_ctrl.sv
`timescale 1ns/1ps
module test_lps_iface_ctrl;
  localparam int unsigned RC = 8;
  localparam int unsigned DC = 20;
  localparam int unsigned IC = 4;
  localparam int NV = 24;

  logic       clk;
  logic       rst_n;
  logic       lps;
  logic [1:0] state;
  logic       ctl_en, lreq_en, lclk_en, brst;

  int checks;
  int failures;
  int pulses;
  bit done;

  lps_iface_ctrl #(
    .RESET_CYCLES  (RC),
    .DISABLE_CYCLES(DC),
    .INIT_CYCLES   (IC)
  ) i_lps_iface_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .lps_i          (lps),
    .state_o        (state),
    .ctl_data_en_o  (ctl_en),
    .lreq_en_o      (lreq_en),
    .lclk_en_o      (lclk_en),
    .bus_reset_req_o(brst)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) if (rst_n && brst) pulses++;

  // {lps, cycles[7:0], state[1:0], ctl, lreq, lclk, pulse, req[3:0]}
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 8'd6,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 steady
    {1'b0, 8'd8,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 low exactly at threshold
    {1'b1, 8'd3,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd1},  // R1
    {1'b0, 8'd8,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 first run
    {1'b1, 8'd1,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 single high
    {1'b0, 8'd8,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 second run
    {1'b1, 8'd2,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd10}, // R10
    {1'b0, 8'd10, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R2 R3
    {1'b0, 8'd12, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
    {1'b0, 8'd30, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 stays
    {1'b1, 8'd1,  2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 pulse
    {1'b1, 8'd1,  2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 4'd7},  // R7 single cycle
    {1'b1, 8'd3,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
    {1'b0, 8'd10, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
    {1'b1, 8'd1,  2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 4'd8},  // R8
    {1'b1, 8'd4,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
    {1'b0, 8'd9,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 one past threshold
    {1'b1, 8'd1,  2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 enters although high
    {1'b1, 8'd1,  2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
    {1'b1, 8'd4,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
    {1'b0, 8'd21, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4},  // R4 one past disable
    {1'b1, 8'd1,  2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 disable wins
    {1'b1, 8'd1,  2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5},  // R5 R7
    {1'b1, 8'd4,  2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6}   // R6
  };

  task automatic check(input string what, input int req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input int req, input int st, input int c, input int q,
                           input int k, input int p);
    check("state", req, int'(state), st);
    check("ctl_data_en", req, int'(ctl_en), c);
    check("lreq_en", req, int'(lreq_en), q);
    check("lclk_en", req, int'(lclk_en), k);
    check("bus_reset_req", req, int'(brst), p);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; pulses = 0; done = 1'b0;
    rst_n = 1'b0;
    lps   = 1'b1;
    step(3);
    check_all(9, 2, 0, 0, 0, 0);              // R9 held disabled in reset
    rst_n = 1'b1;
    step(1);
    check_all(9, 3, 0, 0, 1, 1);              // R9 release behaves as disabled
    step(IC);
    check_all(6, 0, 1, 1, 1, 0);              // R6 back to normal

    for (int i = 0; i < NV; i++) begin
      lps = VEC[i][18];
      step(int'(VEC[i][17:10]));
      check_all(int'(VEC[i][3:0]), int'(VEC[i][9:8]), int'(VEC[i][7]),
                int'(VEC[i][6]), int'(VEC[i][5]), int'(VEC[i][4]));
    end

    // R9: reset asserted from NORMAL takes effect without a clock edge
    rst_n = 1'b0;
    #1;
    check_all(9, 2, 0, 0, 0, 0);
    lps = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(5);
    check_all(9, 2, 0, 0, 0, 0);              // R9 stays disabled while low
    lps = 1'b1;
    step(1);
    check_all(9, 3, 0, 0, 1, 1);              // R9 R7 pulse on exit
    step(IC);
    check_all(6, 0, 1, 1, 1, 0);

    // R7 R8: total requests seen = two disabled exits in the table + two after reset
    check("bus reset pulse count", 7, pulses, 4);

    finish_run();
  end
endmodule